// File: doc/BRIEF.md
# Selectable Divide-by-4/5 Half-Step Ring Clock Divider

This block sits on the receive side of a half-rate serial link. It turns an input clock into a set of clocks at one quarter or one fifth of its rate. These clocks drive a 1:8 or 1:10 deserialiser. A mode input, captured only while reset is held, selects the ratio. The core is a nine-stage ring. Stages at odd positions update on the rising edge of the input clock. Stages at even positions update on the rising edge of the complementary clock. The ring therefore advances one stage per half input period. Because a stage can change at either half of the period, the divider can produce an odd ratio and still hold a controlled duty cycle.

Stage 1 is loaded from a small feedback function of stages 3 and 5. That function drives every possible ring content into the intended cycle within a few steps. In divide-by-4 mode stage 9 is fed from stage 4, which skips stages 5 to 8. In divide-by-5 mode the whole chain of nine stages is used. Combinational taps on stages 2, 3, 4, 5 and 9 form four outputs:
- a word clock and its complement,
- a narrow shift clock for the shift-register chain,
- a 50% clock for the synchronous output stage.

Top module: `ring_clkdiv45`

Timing below is counted in half input periods `h`. `h = 0` is the first rising edge of `clk_i` after `rst_i` is sampled low. A window `[a,b)` repeating every P means the output is high when `h >= a` and `(h-a) mod P < b-a`.

## Requirements
- R1: While `rst_i` is held high across two rising edges of `clk_i`, every stage is cleared. In that state `word_clk_o`, `shift_clk_o` and `sync_clk_o` are 0 and `word_clk_n_o` is 1.
- R2: With `div5_i` low at reset, every output repeats every 8 half-periods (4 input periods). A new shift-clock pulse starts every 4 rising edges of `clk_i`.
- R3: With `div5_i` high at reset, every output repeats every 10 half-periods (5 input periods). A new shift-clock pulse starts every 5 rising edges of `clk_i`.
- R4: `word_clk_o` is high in the window `[1,5)` every 8 half-periods in divide-by-4 mode (1:1). In divide-by-5 mode it is high in `[1,7)` every 10 half-periods (3:2).
- R5: `word_clk_n_o` is always the complement of `word_clk_o`. That gives 1:1 in divide-by-4 mode and 2:3 in divide-by-5 mode.
- R6: `shift_clk_o` is high for exactly one input period per output period, so 1:3 when dividing by 4 and 1:4 when dividing by 5. In divide-by-4 mode the windows are `[4,6)` every 8. In divide-by-5 mode they are `[12,14)` every 10, with no pulse before `h = 12`.
- R7: `sync_clk_o` has a 1:1 duty ratio in both modes. In divide-by-4 mode it is high in `[3,7)` every 8. In divide-by-5 mode it is high in `[4,9)` every 10.
- R8: `div5_i` is sampled only on rising edges of `clk_i` while `rst_i` is high. A change of `div5_i` outside reset leaves every output on the timing of the mode captured at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; its rising edge updates odd-position stages |
| clk_n_i | input | 1 | Complement of `clk_i`; its rising edge updates even-position stages |
| rst_i | input | 1 | Synchronous reset, active high; clears the ring and captures the mode |
| div5_i | input | 1 | Ratio select: 0 divides by 4, 1 divides by 5 (sampled only in reset) |
| word_clk_o | output | 1 | Word clock taken from stage 2 |
| word_clk_n_o | output | 1 | Complement of the word clock |
| shift_clk_o | output | 1 | Narrow clock for the shift-register chain (stage 3 AND stage 9) |
| sync_clk_o | output | 1 | 50% clock for the synchronous output stage |

## Verification
Two things can land in the same cycle:
- the mode input toggling while the ring runs, and
- the feedback step that reloads stage 1.

If the mode were read live, the feedback function and the stage-9 source would switch between the two ring lengths in the middle of a period. The bench provokes this by flipping `div5_i` mid-run, well after reset release, in both directions. It judges the result by requiring every output sample to stay on the window of the mode captured at reset. Reset release also coincides with the first feedback step. The first post-reset samples are compared against windows that start at `h = 0`, so an off-by-one-edge start fails.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // Ring length and the stage positions (1-based in comments, 0-based here).
    localparam int STAGES      = 9;
    localparam int IDX_LAST    = STAGES - 1;   // stage 9
    localparam int IDX_WORD    = 1;            // stage 2
    localparam int IDX_FB_A    = 2;            // stage 3
    localparam int IDX_SYNC    = 3;            // stage 4
    localparam int IDX_FB_B    = 4;            // stage 5
    localparam int IDX_SHORT   = 3;            // stage 4 feeds stage 9 when dividing by 4

    typedef logic [STAGES-1:0] ring_t;

    typedef enum logic {
        DIV_BY_4 = 1'b0,
        DIV_BY_5 = 1'b1
    } div_mode_e;

    typedef struct packed {
        div_mode_e mode;
    } ctrl_t;

    // Bits owned by one phase bank: parity 0 -> odd stage numbers (rising clk_i),
    // parity 1 -> even stage numbers (rising clk_n_i).
    function automatic ring_t phase_mask(input int parity);
        ring_t m;
        for (int i = 0; i < STAGES; i++) begin
            m[i] = ((i % 2) == parity);
        end
        return m;
    endfunction

endpackage

// File: rtl/rcd_feedback.sv
module rcd_feedback (
    input  logic stage3_i,
    input  logic stage5_i,
    input  logic div5_i,
    output logic seed_o
);

    // Divide-by-4: x[n+1] = ~x[n-1]  -> any start falls into 1100.
    // Divide-by-5: x[n+1] = ~(x[n-1] & x[n-2]) -> any start falls into 11100.
    always_comb begin
        if (div5_i) begin
            seed_o = ~(stage3_i & stage5_i);
        end else begin
            seed_o = ~stage3_i;
        end
    end

endmodule

// File: rtl/rcd_phase_bank.sv
module rcd_phase_bank
    import rcd_pkg::*;
#(
    parameter int PARITY = 0
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  ring_t d_i,
    output ring_t q_o
);

    localparam ring_t KEEP = phase_mask(PARITY);

    ring_t q_d;
    ring_t q_q;

    always_comb begin
        q_d = d_i & KEEP;
        if (rst_i) begin
            q_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        q_q <= q_d;
    end

    assign q_o = q_q;

endmodule

// File: rtl/rcd_taps.sv
module rcd_taps (
    input  logic st2_i,
    input  logic st3_i,
    input  logic st4_i,
    input  logic st5_i,
    input  logic st9_i,
    input  logic div5_i,
    output logic word_o,
    output logic word_n_o,
    output logic shift_o,
    output logic sync_o
);

    always_comb begin
        word_o   = st2_i;
        word_n_o = ~st2_i;
        // Stage 3 and stage 9 overlap for two half-periods in either ring length.
        shift_o  = st3_i & st9_i;
        // Odd ratio: trim one half-period off a 3:2 stage to get 5 of 10 high.
        sync_o   = div5_i ? (st4_i & st5_i) : st4_i;
    end

endmodule

// File: rtl/ring_clkdiv45.sv
module ring_clkdiv45
    import rcd_pkg::*;
(
    input  logic clk_i,
    input  logic clk_n_i,
    input  logic rst_i,
    input  logic div5_i,
    output logic word_clk_o,
    output logic word_clk_n_o,
    output logic shift_clk_o,
    output logic sync_clk_o
);

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;
    ring_t ring_d;
    ring_t ring_q;
    ring_t rise_q;
    ring_t fall_q;
    logic  div5_q;
    logic  seed;

    // Mode is captured only while reset is held.
    always_comb begin
        ctrl_d = ctrl_q;
        if (rst_i) begin
            ctrl_d.mode = div5_i ? DIV_BY_5 : DIV_BY_4;
        end
    end

    always_ff @(posedge clk_i) begin
        ctrl_q <= ctrl_d;
    end

    assign div5_q = (ctrl_q.mode == DIV_BY_5);

    rcd_feedback u_fb (
        .stage3_i (ring_q[IDX_FB_A]),
        .stage5_i (ring_q[IDX_FB_B]),
        .div5_i   (div5_q),
        .seed_o   (seed)
    );

    // Next value of every stage; each bank keeps only its own phase.
    always_comb begin
        ring_d    = '0;
        ring_d[0] = seed;
        for (int k = 1; k < STAGES; k++) begin
            ring_d[k] = ring_q[k-1];
        end
        if (!div5_q) begin
            ring_d[IDX_LAST] = ring_q[IDX_SHORT];
        end
    end

    rcd_phase_bank #(.PARITY(0)) u_rise_bank (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (ring_d),
        .q_o   (rise_q)
    );

    rcd_phase_bank #(.PARITY(1)) u_fall_bank (
        .clk_i (clk_n_i),
        .rst_i (rst_i),
        .d_i   (ring_d),
        .q_o   (fall_q)
    );

    assign ring_q = rise_q | fall_q;

    rcd_taps u_taps (
        .st2_i    (ring_q[IDX_WORD]),
        .st3_i    (ring_q[IDX_FB_A]),
        .st4_i    (ring_q[IDX_SYNC]),
        .st5_i    (ring_q[IDX_FB_B]),
        .st9_i    (ring_q[IDX_LAST]),
        .div5_i   (div5_q),
        .word_o   (word_clk_o),
        .word_n_o (word_clk_n_o),
        .shift_o  (shift_clk_o),
        .sync_o   (sync_clk_o)
    );

endmodule

// File: rtl/ring_clkdiv45_chk.sv
module ring_clkdiv45_chk (
    input logic clk_i,
    input logic rst_i,
    input logic div5_q,
    input logic word_clk_o,
    input logic word_clk_n_o,
    input logic shift_clk_o,
    input logic sync_clk_o
);

    logic [1:0] rst_run_q;
    logic       shift_prev_q;
    logic       shift_seen_q;
    logic [3:0] shift_gap_q;
    logic       word_prev_q;
    logic [3:0] word_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rst_run_q <= (rst_run_q == 2'd2) ? 2'd2 : rst_run_q + 2'd1;
        end else begin
            rst_run_q <= 2'd0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_prev_q <= 1'b0;
            shift_seen_q <= 1'b0;
            shift_gap_q  <= 4'd0;
            word_prev_q  <= 1'b0;
            word_run_q   <= 4'd0;
        end else begin
            shift_prev_q <= shift_clk_o;
            if (shift_clk_o && !shift_prev_q) begin
                shift_seen_q <= 1'b1;
                shift_gap_q  <= 4'd1;
            end else if (shift_gap_q != 4'hF) begin
                shift_gap_q  <= shift_gap_q + 4'd1;
            end
            word_prev_q <= word_clk_o;
            word_run_q  <= word_clk_o ? word_run_q + 4'd1 : 4'd0;
        end
    end

    a_r1_idle_in_reset: assert property (@(posedge clk_i)
        (rst_i && rst_run_q == 2'd2) |->
            (!word_clk_o && word_clk_n_o && !shift_clk_o && !sync_clk_o));

    a_r2_period_div4: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_clk_o && !shift_prev_q && shift_seen_q && !div5_q) |-> (shift_gap_q == 4'd4));

    a_r3_period_div5: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_clk_o && !shift_prev_q && shift_seen_q && div5_q) |-> (shift_gap_q == 4'd5));

    a_r6_shift_one_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_clk_o && !shift_prev_q) |=> !shift_clk_o);

    a_r4_word_high_span: assert property (@(posedge clk_i) disable iff (rst_i)
        (!word_clk_o && word_prev_q) |-> (word_run_q == (div5_q ? 4'd3 : 4'd2)));

endmodule

bind ring_clkdiv45 ring_clkdiv45_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .div5_q       (div5_q),
    .word_clk_o   (word_clk_o),
    .word_clk_n_o (word_clk_n_o),
    .shift_clk_o  (shift_clk_o),
    .sync_clk_o   (sync_clk_o)
);

// File: tb/ring_clkdiv45_tb.sv
`timescale 1ns/1ps
module ring_clkdiv45_tb;

    logic clk = 1'b0;
    logic clk_n;
    logic rst = 1'b1;
    logic div5 = 1'b0;
    logic word_clk, word_clk_n, shift_clk, sync_clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int acc_word, acc_sync, acc_shift;

    assign clk_n = ~clk;
    always #5 clk = ~clk;

    ring_clkdiv45 u_dut (
        .clk_i        (clk),
        .clk_n_i      (clk_n),
        .rst_i        (rst),
        .div5_i       (div5),
        .word_clk_o   (word_clk),
        .word_clk_n_o (word_clk_n),
        .shift_clk_o  (shift_clk),
        .sync_clk_o   (sync_clk)
    );

    task automatic check_bit(input string req, input int h, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s h=%0d actual=%0b expected=%0b", req, h, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // High when h lies in [start, start+len) repeated every per half-periods.
    function automatic logic in_win(input int h, input int start, input int len, input int per);
        if (h < start) return 1'b0;
        return ((h - start) % per) < len;
    endfunction

    task automatic sample(input string ctx, input bit mode, input int h);
        int   per;
        logic e_word, e_shift, e_sync;
        per = mode ? 10 : 8;
        if (mode) begin
            e_word  = in_win(h, 1, 6, 10);   // R4
            e_shift = in_win(h, 12, 2, 10);  // R6
            e_sync  = in_win(h, 4, 5, 10);   // R7
        end else begin
            e_word  = in_win(h, 1, 4, 8);
            e_shift = in_win(h, 4, 2, 8);
            e_sync  = in_win(h, 3, 4, 8);
        end
        check_bit({ctx, " R4 word"},   h, word_clk,   e_word);
        check_bit({ctx, " R5 word_n"}, h, word_clk_n, ~e_word);
        check_bit({ctx, " R6 shift"},  h, shift_clk,  e_shift);
        check_bit({ctx, " R7 sync"},   h, sync_clk,   e_sync);
        if (h >= 30 && h < 30 + per) begin
            acc_word  += int'(word_clk);
            acc_sync  += int'(sync_clk);
            acc_shift += int'(shift_clk);
        end
    endtask

    task automatic run(input string ctx, input bit mode, input bit flip);
        @(posedge clk); #2.5;
        rst  = 1'b1;
        div5 = mode;
        repeat (3) @(posedge clk);
        #2.5;
        check_bit({ctx, " R1 word"},   -1, word_clk,   1'b0);
        check_bit({ctx, " R1 word_n"}, -1, word_clk_n, 1'b1);
        check_bit({ctx, " R1 shift"},  -1, shift_clk,  1'b0);
        check_bit({ctx, " R1 sync"},   -1, sync_clk,   1'b0);
        acc_word = 0; acc_sync = 0; acc_shift = 0;
        rst = 1'b0;
        for (int h = 0; h < 60; h += 2) begin
            @(posedge clk); #2.5;
            sample(ctx, mode, h);
            @(negedge clk); #2.5;
            sample(ctx, mode, h + 1);
            if (flip && h == 20) div5 = ~mode;   // R8: no effect outside reset
        end
        // Duty over one full period (R4, R6, R7), period set by R2 / R3
        check_int({ctx, " R4 word high halves"},  acc_word,  mode ? 6 : 4);
        check_int({ctx, " R7 sync high halves"},  acc_sync,  mode ? 5 : 4);
        check_int({ctx, " R6 shift high halves"}, acc_shift, 2);
    endtask

    initial begin
        run("R2", 1'b0, 1'b0);
        run("R3", 1'b1, 1'b0);
        run("R8", 1'b0, 1'b1);
        run("R8", 1'b1, 1'b1);
        run("R2", 1'b0, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule